// File: doc/BRIEF.md
# Nonvolatile Page Erase and Byte Program Controller

This block accepts byte program and page erase requests for an emulated nonvolatile array held in a register file. It enforces the rules of a flash-like store. Erasure works only on whole 32-byte pages and returns every byte of the page to 0xFF. A byte can be programmed only while it is still blank (0xFF). Erasure can be locked out by a control input.

Each accepted operation starts a busy period whose length is a parameter in clock cycles. The serial bus front end uses `busy` to NACK new transfers while an erase runs. It uses `stretch` to hold the clock low while a byte program finishes, before it takes the next byte of a block write. A refused request raises a one-cycle error pulse together with a reason code. A read port returns array contents one cycle after the read is requested, but only while the block is idle.

Top module: `nvm_pe_ctrl`

## Requirements
- R1: Only addresses from BASE_ADDR (default 0xF800) up to BASE_ADDR+ARRAY_BYTES-1 (default 0xFBFF) are valid. A program or erase request outside that range is refused with code 1 and leaves the array unchanged.
- R2: An accepted erase sets all PAGE_BYTES bytes of the addressed page to 0xFF. The page is given by address offset bits [9:5], and the five low address bits are ignored. Other pages keep their contents.
- R3: An erase request (req_op=1) made while erase_en is 0 is refused with code 3 and changes no byte.
- R4: A program request (req_op=0) is accepted only if the addressed byte reads 0xFF, and then the byte takes req_data. Otherwise the request is refused with code 2 and the byte keeps its value.
- R5: A refused request drives `err` high for exactly the one cycle after the clock edge that sampled it, with `err_code` set to 0 (busy), 1 (range), 2 (not blank) or 3 (erase locked). A refused request never starts a busy period.
- R6: `busy` rises in the cycle after an accepted request. It stays high for exactly ERASE_CYCLES cycles after an erase, or PROG_CYCLES cycles after a program.
- R7: `stretch` is high in every busy cycle of a program and low throughout an erase and while idle.
- R8: A request made while `busy` is high is refused with code 0 and has no effect on the array.
- R9: A read with rd_en high while idle puts the addressed byte on rd_data one cycle later, or 0x00 if the address is out of range. A read requested while busy is ignored, and rd_data holds its value.
- R10: After reset, busy, stretch and err are 0, rd_data is 0x00, and every array byte is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled each rising edge |
| req_op | input | 1 | 0 = byte program, 1 = page erase |
| req_addr | input | 16 | Byte address of the request |
| req_data | input | 8 | Byte to program |
| erase_en | input | 1 | Erase permission, 1 = allowed |
| busy | output | 1 | Operation in progress; bus side NACKs |
| stretch | output | 1 | Program in progress; bus side holds clock low |
| err | output | 1 | One-cycle pulse for a refused request |
| err_code | output | 2 | Reason for the last refusal |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 16 | Read byte address |
| rd_data | output | 8 | Read data, one cycle after rd_en |

## Verification
Suppose the countdown is loaded with the wrong value or a refusal still starts it. Then `busy` has the wrong length, or rises at the wrong time, in the very next cycle, and the cycle-count checks catch it. A wrong page index or wrong blank test does not show at once. It appears at the next read of a neighbouring page, or at the next program of the same byte. For that reason each erase and program is followed by a read-back, sometimes of an untouched page. If the program flag is stale, `stretch` takes the wrong level during an erase, and per-cycle sampling exposes it at once.

// File: rtl/nvm_pe_pkg.sv
package nvm_pe_pkg;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } nvm_op_e;

    typedef enum logic [1:0] {
        ERR_BUSY      = 2'd0,
        ERR_RANGE     = 2'd1,
        ERR_NOT_BLANK = 2'd2,
        ERR_LOCKED    = 2'd3
    } nvm_err_e;

    typedef struct packed {
        logic     prog_busy;
        logic     err;
        nvm_err_e code;
    } ctrl_s;

endpackage

// File: rtl/nvm_pe_timer.sv
module nvm_pe_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    output logic             running
);
    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (start)
            count_d = load;
        else if (count_q != '0)
            count_d = count_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign running = (count_q != '0);
endmodule

// File: rtl/nvm_pe_array.sv
module nvm_pe_array #(
    parameter int BYTES      = 1024,
    parameter int PAGE_BYTES = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(BYTES)-1:0] wr_idx,
    input  logic [7:0]               wr_data,
    input  logic                     erase,
    input  logic [$clog2(BYTES)-$clog2(PAGE_BYTES)-1:0] erase_page,
    input  logic [$clog2(BYTES)-1:0] probe_idx,
    output logic [7:0]               probe_data,
    input  logic                     rd_en,
    input  logic                     rd_in_range,
    input  logic [$clog2(BYTES)-1:0] rd_idx,
    output logic [7:0]               rd_data
);
    localparam int IDX_W = $clog2(BYTES);
    localparam int OFF_W = $clog2(PAGE_BYTES);

    logic [7:0] mem [BYTES];
    logic [7:0] rd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) mem[i] <= 8'hFF;
            rd_q <= 8'h00;
        end else begin
            if (wr_en) mem[wr_idx] <= wr_data;
            if (erase) begin
                for (int i = 0; i < PAGE_BYTES; i++)
                    mem[{erase_page, OFF_W'(i)}] <= 8'hFF;
            end
            if (rd_en) rd_q <= rd_in_range ? mem[rd_idx] : 8'h00;
        end
    end

    assign probe_data = mem[probe_idx];
    assign rd_data    = rd_q;

    logic [IDX_W-1:0] unused_chk;
    assign unused_chk = '0;
endmodule

// File: rtl/nvm_pe_ctrl.sv
module nvm_pe_ctrl
    import nvm_pe_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR    = 16'hF800,
    parameter int          ARRAY_BYTES  = 1024,
    parameter int          PAGE_BYTES   = 32,
    parameter int          ERASE_CYCLES = 1000000,
    parameter int          PROG_CYCLES  = 12500
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_op,
    input  logic [15:0] req_addr,
    input  logic [7:0]  req_data,
    input  logic        erase_en,
    output logic        busy,
    output logic        stretch,
    output logic        err,
    output logic [1:0]  err_code,
    input  logic        rd_en,
    input  logic [15:0] rd_addr,
    output logic [7:0]  rd_data
);
    localparam int IDX_W   = $clog2(ARRAY_BYTES);
    localparam int OFF_W   = $clog2(PAGE_BYTES);
    localparam int PAGE_W  = IDX_W - OFF_W;
    localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [16:0] SPAN = 17'(ARRAY_BYTES);

    ctrl_s q, d;

    logic [15:0]       req_off, rd_off;
    logic              req_in_range, rd_in_range;
    logic [IDX_W-1:0]  req_idx, rd_idx;
    logic [PAGE_W-1:0] req_page;
    logic [7:0]        probe_data;
    logic              take_prog, take_erase;
    logic [CNT_W-1:0]  load_val;

    // Address decode relative to the array base
    assign req_off      = req_addr - BASE_ADDR;
    assign rd_off       = rd_addr - BASE_ADDR;
    assign req_in_range = (req_addr >= BASE_ADDR) && ({1'b0, req_off} < SPAN);
    assign rd_in_range  = (rd_addr >= BASE_ADDR) && ({1'b0, rd_off} < SPAN);
    assign req_idx      = req_off[IDX_W-1:0];
    assign rd_idx       = rd_off[IDX_W-1:0];
    assign req_page     = req_idx[IDX_W-1:OFF_W];

    always_comb begin
        d          = q;
        d.err      = 1'b0;
        take_prog  = 1'b0;
        take_erase = 1'b0;
        if (req_valid) begin
            if (busy) begin
                d.err  = 1'b1;
                d.code = ERR_BUSY;
            end else if (!req_in_range) begin
                d.err  = 1'b1;
                d.code = ERR_RANGE;
            end else if (nvm_op_e'(req_op) == OP_ERASE) begin
                if (!erase_en) begin
                    d.err  = 1'b1;
                    d.code = ERR_LOCKED;
                end else begin
                    take_erase  = 1'b1;
                    d.prog_busy = 1'b0;
                end
            end else begin
                if (probe_data != 8'hFF) begin
                    d.err  = 1'b1;
                    d.code = ERR_NOT_BLANK;
                end else begin
                    take_prog   = 1'b1;
                    d.prog_busy = 1'b1;
                end
            end
        end
        load_val = take_erase ? CNT_W'(ERASE_CYCLES) : CNT_W'(PROG_CYCLES);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{prog_busy: 1'b0, err: 1'b0, code: ERR_BUSY};
        else        q <= d;
    end

    nvm_pe_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (take_prog | take_erase),
        .load    (load_val),
        .running (busy)
    );

    nvm_pe_array #(.BYTES(ARRAY_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (take_prog),
        .wr_idx      (req_idx),
        .wr_data     (req_data),
        .erase       (take_erase),
        .erase_page  (req_page),
        .probe_idx   (req_idx),
        .probe_data  (probe_data),
        .rd_en       (rd_en && !busy),
        .rd_in_range (rd_in_range),
        .rd_idx      (rd_idx),
        .rd_data     (rd_data)
    );

    assign stretch  = busy && q.prog_busy;
    assign err      = q.err;
    assign err_code = q.code;
endmodule

// File: rtl/nvm_pe_ctrl_chk.sv
module nvm_pe_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_op,
    input logic       busy,
    input logic       stretch,
    input logic       err,
    input logic [1:0] err_code,
    input logic [7:0] rd_data
);
    p_busy_needs_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    p_err_needs_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(req_valid));

    p_refusal_no_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !$rose(busy));

    p_stretch_inside_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stretch |-> busy);

    p_stretch_from_program_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stretch) |-> ($past(req_valid) && !$past(req_op)));

    p_busy_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err && err_code == 2'd0) |-> $past(busy));

    p_read_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(rd_data));
endmodule

bind nvm_pe_ctrl nvm_pe_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .busy      (busy),
    .stretch   (stretch),
    .err       (err),
    .err_code  (err_code),
    .rd_data   (rd_data)
);

// File: tb/sim_nvm_pe_ctrl.sv
`timescale 1ns/1ps
module sim_nvm_pe_ctrl;
    localparam int ERASE_CYC = 40;
    localparam int PROG_CYC  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_op = 1'b0, erase_en = 1'b0, rd_en = 1'b0;
    logic [15:0] req_addr = '0, rd_addr = '0;
    logic [7:0]  req_data = '0;
    logic        busy, stretch, err;
    logic [1:0]  err_code;
    logic [7:0]  rd_data;

    int n_vec = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nvm_pe_ctrl #(.ERASE_CYCLES(ERASE_CYC), .PROG_CYCLES(PROG_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .erase_en(erase_en),
        .busy(busy), .stretch(stretch), .err(err), .err_code(err_code),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // {op, addr, data, erase_en, exp_err, exp_code, readback addr, readback value}
    localparam int NV = 12;
    localparam logic [52:0] VECS [NV] = '{
        {1'b0, 16'hF800, 8'hA5, 1'b0, 1'b0, 2'd0, 16'hF800, 8'hA5}, // R4 program blank
        {1'b0, 16'hF800, 8'h3C, 1'b0, 1'b1, 2'd2, 16'hF800, 8'hA5}, // R4 not blank
        {1'b0, 16'hFBFF, 8'h11, 1'b0, 1'b0, 2'd0, 16'hFBFF, 8'h11}, // R1 top byte
        {1'b0, 16'hFC00, 8'h22, 1'b0, 1'b1, 2'd1, 16'hFC00, 8'h00}, // R1 R9 above
        {1'b0, 16'hF7FF, 8'h22, 1'b0, 1'b1, 2'd1, 16'hF800, 8'hA5}, // R1 below
        {1'b1, 16'hF805, 8'h00, 1'b0, 1'b1, 2'd3, 16'hF800, 8'hA5}, // R3 locked
        {1'b1, 16'hF81F, 8'h00, 1'b1, 1'b0, 2'd0, 16'hF800, 8'hFF}, // R2 erase page 0
        {1'b0, 16'hF800, 8'h3C, 1'b0, 1'b0, 2'd0, 16'hF800, 8'h3C}, // R4 after erase
        {1'b0, 16'hF820, 8'h77, 1'b0, 1'b0, 2'd0, 16'hF820, 8'h77}, // R4 page 1
        {1'b1, 16'hF800, 8'h00, 1'b1, 1'b0, 2'd0, 16'hF820, 8'h77}, // R2 neighbour kept
        {1'b1, 16'hFBE0, 8'h00, 1'b1, 1'b0, 2'd0, 16'hFBFF, 8'hFF}, // R2 last page
        {1'b0, 16'hFBFF, 8'h11, 1'b0, 1'b0, 2'd0, 16'hFBFF, 8'h11}  // R4 reprogram
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic run_req(input logic op, input logic [15:0] a, input logic [7:0] dv,
                           input logic en, input logic xerr, input logic [1:0] xcode);
        int cnt;
        bit st_bad;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = dv; erase_en = en;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R5 err pulse", err, xerr);
        if (xerr) chk("R5 err code", err_code, xcode);
        chk("R6 busy start", busy, !xerr);
        cnt = 0; st_bad = 1'b0;
        while (busy) begin
            cnt++;
            if (stretch !== !op) st_bad = 1'b1;
            @(negedge clk);
        end
        if (!xerr) begin
            chk("R6 busy length", cnt, op ? ERASE_CYC : PROG_CYC);
            chk("R7 stretch level", st_bad, 0);
        end
        @(negedge clk);
        chk("R5 err single cycle", err, 0);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 busy reset", busy, 0);
        chk("R10 stretch reset", stretch, 0);
        chk("R10 err reset", err, 0);
        chk("R10 rd_data reset", rd_data, 0);
        do_read(16'hF9AB, v);
        chk("R10 array blank", v, 8'hFF);

        for (int i = 0; i < NV; i++) begin
            logic [52:0] t;
            t = VECS[i];
            run_req(t[52], t[51:36], t[35:28], t[27], t[26], t[25:24]);
            do_read(t[23:8], v);
            chk("R1/R2/R3/R4 readback", v, t[7:0]);
        end

        // R8/R9: request and read while a program is busy
        @(negedge clk);
        req_valid = 1'b1; req_op = 1'b0; req_addr = 16'hF840; req_data = 8'h5A;
        @(negedge clk);
        chk("R6 busy after accept", busy, 1);
        req_op = 1'b0; req_addr = 16'hF800; req_data = 8'h11;
        rd_en = 1'b1; rd_addr = 16'hF840;
        @(negedge clk);
        req_valid = 1'b0; rd_en = 1'b0;
        chk("R8 refused while busy", err, 1);
        chk("R8 busy code", err_code, 0);
        chk("R9 read ignored while busy", rd_data, 8'h11);
        while (busy) @(negedge clk);
        do_read(16'hF800, v);
        chk("R8 array untouched", v, 8'hFF);
        do_read(16'hF840, v);
        chk("R4 program during test", v, 8'h5A);
        chk("R7 stretch idle", stretch, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule